// File: doc/BRIEF.md
# Load-Store Disambiguation Queue

This block sits between dispatch and the memory pipeline of an out-of-order core. Memory operations enter in program order, each carrying its reorder tag. Their addresses and store data arrive later as tagged notices. Each cycle the block picks at most one operation that can leave without breaking memory ordering. Stores leave without touching memory. Each one leaves its address and reorder tag behind in a store address buffer, where they stay until the commit logic retires that store. A departing load is told whether to read the cache or to take its value from an older in-flight store, which the block names by reorder tag.

A younger store may overtake a load that is still waiting. Each waiting load counts the overtaking stores that match its address. When the load finally issues, the forwarding search walks the store address buffer from its youngest entry and passes over that many matches. This keeps the search from selecting a store that is younger than the load.

Top module: `ldst_disambig`

## Requirements
- R1: The queue holds up to DEPTH (8) operations in program order. `q_full` is high exactly when 8 are held. An enqueue offered while `q_full` is high is dropped and never issues.
- R2: Address and data notices update only the held entry whose reorder tag equals the notice tag. A notice carrying an unheld tag has no effect.
- R3: A load issues only when three conditions hold: its address is known, no older store is still waiting in the queue, and `cache_rdy` is high.
- R4: A store issues only when four conditions hold: its address and data are known, no older store is still waiting, no older load lacks its address, and the store address buffer is not full.
- R5: At most one operation issues per cycle. Among the ready operations, the oldest wins.
- R6: An issued store enters the store address buffer. A commit notice removes the oldest buffer entry when the notice tag equals that entry's tag. A commit notice with any other tag leaves the buffer unchanged.
- R7: A load issues with `ld_cache_rd`=1 and `ld_fwd`=0 when the buffer holds no older store with an equal full-word address.
- R8: A load issues with `ld_fwd`=1, `ld_cache_rd`=0 and `fwd_tag` equal to the tag of the youngest older store with an equal address.
- R9: Each issuing store increments the match count of every older waiting load that has an equal known address. At issue, the load's forwarding search passes over that many of the youngest matching buffer entries.
- R10: After reset the queue and the buffer are empty, `q_full` is low and nothing issues. While `iss_vld` is low, all issue outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| enq_vld | input | 1 | enqueue a memory operation |
| enq_st | input | 1 | 1 = store, 0 = load |
| enq_tag | input | 5 | reorder tag of the enqueued operation |
| adr_vld | input | 1 | address notice valid |
| adr_tag | input | 5 | tag the address belongs to |
| adr_val | input | 32 | full word address |
| dat_vld | input | 1 | store data known notice |
| dat_tag | input | 5 | tag of the store whose data is known |
| cm_vld | input | 1 | store commit notice |
| cm_tag | input | 5 | tag of the committing store |
| cache_rdy | input | 1 | cache read port can accept a load |
| q_full | output | 1 | queue holds DEPTH operations |
| iss_vld | output | 1 | an operation issues this cycle |
| iss_st | output | 1 | issuing operation is a store |
| iss_tag | output | 5 | tag of the issuing operation |
| iss_addr | output | 32 | address of the issuing operation |
| ld_cache_rd | output | 1 | issuing load reads the cache |
| ld_fwd | output | 1 | issuing load takes forwarded store data |
| fwd_tag | output | 5 | tag of the store supplying forwarded data |

## Verification
A store can issue into the store address buffer in the same cycle that a commit notice removes the buffer's oldest entry. The buffer must then shift and append in one step, without losing or duplicating an entry. The bench provokes this by sending the commit of one buffered store in the cycle when a second store issues. Two later loads check the result: one whose address matches only the retired store must read the cache, and one matching the new store must be forwarded from it.

// File: rtl/ldst_pkg.sv
// Shared widths and the queue slot type for the load-store disambiguation queue.
// Assumes reorder tags are unique among operations in flight.
package ldst_pkg;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 5;
    localparam int MCNT_W = 4;   // must count up to the store buffer depth

    typedef struct packed {
        logic              is_st;
        logic [TAG_W-1:0]  tag;
        logic              addr_ok;
        logic [ADDR_W-1:0] addr;
        logic              data_ok;
        logic [MCNT_W-1:0] mcnt;
    } slot_t;
endpackage

// File: rtl/ldst_queue.sv
// Age-ordered waiting queue. Slot 0 is the oldest entry. An issue removes one slot and
// compacts the younger slots down; an enqueue appends behind the last held slot.
// Applies tagged address/data notices and counts the overtaking stores that match.
// Assumes the issue index always points at a held slot.
module ldst_queue
    import ldst_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_vld,
    input  logic              enq_st,
    input  logic [TAG_W-1:0]  enq_tag,
    input  logic              adr_vld,
    input  logic [TAG_W-1:0]  adr_tag,
    input  logic [ADDR_W-1:0] adr_val,
    input  logic              dat_vld,
    input  logic [TAG_W-1:0]  dat_tag,
    input  logic              iss,
    input  logic [IW-1:0]     iss_idx,
    output logic              full,
    output logic [DEPTH-1:0]  vld_v,
    output logic [DEPTH-1:0]  st_v,
    output logic [DEPTH-1:0]  aok_v,
    output logic [DEPTH-1:0]  dok_v,
    output logic              sel_st,
    output logic [TAG_W-1:0]  sel_tag,
    output logic [ADDR_W-1:0] sel_addr,
    output logic [MCNT_W-1:0] sel_mcnt
);
    slot_t          ent [DEPTH];
    slot_t          upd [DEPTH];
    slot_t          nxt [DEPTH];
    slot_t          sel;
    slot_t          new_e;
    logic [CW-1:0]  cnt, cnt_mid, cnt_nxt;
    logic           enq_ok, st_iss;

    assign sel      = ent[iss_idx];
    assign sel_st   = sel.is_st;
    assign sel_tag  = sel.tag;
    assign sel_addr = sel.addr;
    assign sel_mcnt = sel.mcnt;
    assign st_iss   = iss && sel.is_st;
    assign full     = (cnt == CW'(DEPTH));
    assign enq_ok   = enq_vld && !full;

    // flat status vectors for the picker
    for (genvar g = 0; g < DEPTH; g++) begin : g_vec
        assign vld_v[g] = (CW'(g) < cnt);
        assign st_v[g]  = ent[g].is_st;
        assign aok_v[g] = ent[g].addr_ok;
        assign dok_v[g] = ent[g].data_ok;
    end

    // apply notices and overtaking-store match counting in place
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            upd[i] = ent[i];
            if (CW'(i) < cnt) begin
                if (adr_vld && ent[i].tag == adr_tag && !ent[i].addr_ok) begin
                    upd[i].addr_ok = 1'b1;
                    upd[i].addr    = adr_val;
                end
                if (dat_vld && ent[i].tag == dat_tag)
                    upd[i].data_ok = 1'b1;
                if (st_iss && IW'(i) < iss_idx && !ent[i].is_st && ent[i].addr_ok &&
                    ent[i].addr == sel.addr && ent[i].mcnt != '1)
                    upd[i].mcnt = ent[i].mcnt + 1'b1;
            end
        end
    end

    // compact over the issued slot, then append the new entry
    always_comb begin
        new_e         = '0;
        new_e.is_st   = enq_st;
        new_e.tag     = enq_tag;
        cnt_mid       = cnt - CW'(iss);
        for (int i = 0; i < DEPTH - 1; i++)
            nxt[i] = (iss && IW'(i) >= iss_idx) ? upd[i + 1] : upd[i];
        nxt[DEPTH - 1] = upd[DEPTH - 1];
        for (int i = 0; i < DEPTH; i++)
            if (enq_ok && CW'(i) == cnt_mid) nxt[i] = new_e;
        cnt_nxt = cnt_mid + CW'(enq_ok);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            cnt <= cnt_nxt;
            for (int i = 0; i < DEPTH; i++) ent[i] <= nxt[i];
        end
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R1
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !iss) |=> full);
endmodule

// File: rtl/ldst_pick.sv
// Readiness evaluation and oldest-first selection over the age-ordered queue.
// Purely combinational; assumes slot 0 is the oldest entry.
module ldst_pick #(
    parameter  int DEPTH = 8,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vld_v,
    input  logic [DEPTH-1:0] st_v,
    input  logic [DEPTH-1:0] aok_v,
    input  logic [DEPTH-1:0] dok_v,
    input  logic             cache_rdy,
    input  logic             sab_full,
    output logic             iss,
    output logic [IW-1:0]    iss_idx,
    output logic [DEPTH-1:0] gnt
);
    logic [DEPTH-1:0] rdy;
    logic             older_st, older_ld_na, taken;

    // per-slot ordering rules, accumulated from the oldest slot upward
    always_comb begin
        older_st    = 1'b0;
        older_ld_na = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_v[i])
                rdy[i] = vld_v[i] && aok_v[i] && dok_v[i] && !older_st &&
                         !older_ld_na && !sab_full;
            else
                rdy[i] = vld_v[i] && aok_v[i] && !older_st && cache_rdy;
            older_st    = older_st || (vld_v[i] && st_v[i]);
            older_ld_na = older_ld_na || (vld_v[i] && !st_v[i] && !aok_v[i]);
        end
    end

    // lowest ready slot wins
    always_comb begin
        taken   = 1'b0;
        iss_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            gnt[i] = rdy[i] && !taken;
            if (gnt[i]) iss_idx = IW'(i);
            taken = taken || rdy[i];
        end
        iss = taken;
    end
endmodule

// File: rtl/ldst_sab.sv
// Store address buffer: address and tag of issued, uncommitted stores, kept in issue
// order (slot 0 oldest). Pops the oldest entry on a matching commit notice.
// Searches from the youngest entry for a load's forwarding source, skipping a count.
// Assumes stores commit in program order and push is never offered while full.
module ldst_sab
    import ldst_pkg::*;
#(
    parameter  int SAB_DEPTH = 8,
    localparam int SW        = $clog2(SAB_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              cm_vld,
    input  logic [TAG_W-1:0]  cm_tag,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [MCNT_W-1:0] skip,
    output logic              full,
    output logic              hit,
    output logic [TAG_W-1:0]  hit_tag
);
    logic [ADDR_W-1:0] s_addr [SAB_DEPTH];
    logic [TAG_W-1:0]  s_tag  [SAB_DEPTH];
    logic [ADDR_W-1:0] n_addr [SAB_DEPTH];
    logic [TAG_W-1:0]  n_tag  [SAB_DEPTH];
    logic [SW-1:0]     cnt, cnt_mid, cnt_nxt;
    logic [MCNT_W-1:0] seen;
    logic              pop;

    assign full = (cnt == SW'(SAB_DEPTH));
    assign pop  = cm_vld && (cnt != '0) && (s_tag[0] == cm_tag);

    // pop the oldest, then append the issuing store
    always_comb begin
        cnt_mid = cnt - SW'(pop);
        for (int i = 0; i < SAB_DEPTH - 1; i++) begin
            n_addr[i] = pop ? s_addr[i + 1] : s_addr[i];
            n_tag[i]  = pop ? s_tag[i + 1]  : s_tag[i];
        end
        n_addr[SAB_DEPTH - 1] = s_addr[SAB_DEPTH - 1];
        n_tag[SAB_DEPTH - 1]  = s_tag[SAB_DEPTH - 1];
        for (int i = 0; i < SAB_DEPTH; i++)
            if (push && SW'(i) == cnt_mid) begin
                n_addr[i] = push_addr;
                n_tag[i]  = push_tag;
            end
        cnt_nxt = cnt_mid + SW'(push);
    end

    // youngest-first match search, passing over 'skip' matches
    always_comb begin
        hit     = 1'b0;
        hit_tag = '0;
        seen    = '0;
        for (int i = SAB_DEPTH - 1; i >= 0; i--) begin
            if (SW'(i) < cnt && s_addr[i] == q_addr && !hit) begin
                if (seen == skip) begin
                    hit     = 1'b1;
                    hit_tag = s_tag[i];
                end else begin
                    seen = seen + 1'b1;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < SAB_DEPTH; i++) begin
                s_addr[i] <= '0;
                s_tag[i]  <= '0;
            end
        end else begin
            cnt <= cnt_nxt;
            for (int i = 0; i < SAB_DEPTH; i++) begin
                s_addr[i] <= n_addr[i];
                s_tag[i]  <= n_tag[i];
            end
        end
    end

    // R6
    sab_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= SW'(SAB_DEPTH));
    // R6
    commit_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (cnt + SW'(1) == $past(cnt)));
    // R6
    foreign_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_vld && !pop && !push) |=> $stable(cnt));
endmodule

// File: rtl/ldst_disambig.sv
// Top of the load-store disambiguation queue: waiting queue, issue picker and store
// address buffer. Issue outputs are combinational from state and cache_rdy and are
// all zero when nothing issues. Assumes in-order commit notices for stores.
module ldst_disambig
    import ldst_pkg::*;
#(
    parameter  int DEPTH     = 8,
    parameter  int SAB_DEPTH = 8,
    localparam int IW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_vld,
    input  logic              enq_st,
    input  logic [TAG_W-1:0]  enq_tag,
    input  logic              adr_vld,
    input  logic [TAG_W-1:0]  adr_tag,
    input  logic [ADDR_W-1:0] adr_val,
    input  logic              dat_vld,
    input  logic [TAG_W-1:0]  dat_tag,
    input  logic              cm_vld,
    input  logic [TAG_W-1:0]  cm_tag,
    input  logic              cache_rdy,
    output logic              q_full,
    output logic              iss_vld,
    output logic              iss_st,
    output logic [TAG_W-1:0]  iss_tag,
    output logic [ADDR_W-1:0] iss_addr,
    output logic              ld_cache_rd,
    output logic              ld_fwd,
    output logic [TAG_W-1:0]  fwd_tag
);
    logic [DEPTH-1:0]  vld_v, st_v, aok_v, dok_v, gnt;
    logic              iss, sab_full, sel_st, hit;
    logic [IW-1:0]     iss_idx;
    logic [TAG_W-1:0]  sel_tag, hit_tag;
    logic [ADDR_W-1:0] sel_addr;
    logic [MCNT_W-1:0] sel_mcnt;

    ldst_queue #(.DEPTH(DEPTH)) u_queue (
        .clk, .rst_n, .enq_vld, .enq_st, .enq_tag, .adr_vld, .adr_tag, .adr_val,
        .dat_vld, .dat_tag, .iss, .iss_idx, .full(q_full), .vld_v, .st_v, .aok_v,
        .dok_v, .sel_st, .sel_tag, .sel_addr, .sel_mcnt
    );

    ldst_pick #(.DEPTH(DEPTH)) u_pick (
        .vld_v, .st_v, .aok_v, .dok_v, .cache_rdy, .sab_full, .iss, .iss_idx, .gnt
    );

    ldst_sab #(.SAB_DEPTH(SAB_DEPTH)) u_sab (
        .clk, .rst_n, .push(iss && sel_st), .push_addr(sel_addr), .push_tag(sel_tag),
        .cm_vld, .cm_tag, .q_addr(sel_addr), .skip(sel_mcnt), .full(sab_full),
        .hit, .hit_tag
    );

    // issue outputs, gated to zero when idle
    always_comb begin
        iss_vld     = iss;
        iss_st      = iss && sel_st;
        iss_tag     = iss ? sel_tag : '0;
        iss_addr    = iss ? sel_addr : '0;
        ld_cache_rd = iss && !sel_st && !hit;
        ld_fwd      = iss && !sel_st && hit;
        fwd_tag     = ld_fwd ? hit_tag : '0;
    end

    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (iss == (gnt != '0)));
    // R3
    ld_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !iss_st) |-> cache_rdy);
    // R4
    st_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && iss_st) |-> !sab_full);
    // R7
    ld_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !iss_st) |-> $onehot({ld_cache_rd, ld_fwd}));
    // R8
    st_no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_st |-> !(ld_cache_rd || ld_fwd));
endmodule

// File: tb/test_ldst_disambig.sv
// Directed bench: one task per scenario, each checking its own results.
module test_ldst_disambig;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        enq_vld = 0, enq_st = 0, adr_vld = 0, dat_vld = 0, cm_vld = 0, cache_rdy = 0;
    logic [4:0]  enq_tag = 0, adr_tag = 0, dat_tag = 0, cm_tag = 0;
    logic [31:0] adr_val = 0;
    logic        q_full, iss_vld, iss_st, ld_cache_rd, ld_fwd;
    logic [4:0]  iss_tag, fwd_tag;
    logic [31:0] iss_addr;
    int          total = 0, bad = 0;

    always #(CLK_P / 2) clk = ~clk;

    ldst_disambig i_ldst_disambig (
        .clk, .rst_n, .enq_vld, .enq_st, .enq_tag, .adr_vld, .adr_tag, .adr_val,
        .dat_vld, .dat_tag, .cm_vld, .cm_tag, .cache_rdy, .q_full, .iss_vld, .iss_st,
        .iss_tag, .iss_addr, .ld_cache_rd, .ld_fwd, .fwd_tag
    );

    task automatic tick();
        @(posedge clk); #1;
        enq_vld = 0; adr_vld = 0; dat_vld = 0; cm_vld = 0;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] obs();
        return {18'd0, iss_vld, iss_st, iss_tag, ld_cache_rd, ld_fwd, fwd_tag};
    endfunction

    task automatic exp_none(input string req);
        #1 chk(req, "no issue", obs(), 32'd0);
    endtask
    task automatic exp_st(input string req, input logic [4:0] t);
        #1 chk(req, "store issue", obs(), {18'd0, 1'b1, 1'b1, t, 2'b00, 5'd0});
    endtask
    task automatic exp_ld(input string req, input logic [4:0] t, input logic fw,
                          input logic [4:0] ft);
        #1 chk(req, "load issue", obs(), {18'd0, 1'b1, 1'b0, t, !fw, fw, fw ? ft : 5'd0});
    endtask

    task automatic put_enq(input logic st, input logic [4:0] t);
        enq_vld = 1; enq_st = st; enq_tag = t;
    endtask
    task automatic put_adr(input logic [4:0] t, input logic [31:0] a);
        adr_vld = 1; adr_tag = t; adr_val = a;
    endtask
    task automatic put_dat(input logic [4:0] t);
        dat_vld = 1; dat_tag = t;
    endtask
    task automatic put_cm(input logic [4:0] t);
        cm_vld = 1; cm_tag = t;
    endtask

    // R10: reset state
    task automatic t_reset();
        #1 chk("R10", "q_full after reset", {31'd0, q_full}, 32'd0);
        exp_none("R10");
    endtask

    // R2 foreign notice, R7 cache read
    task automatic t_cache_read();
        cache_rdy = 1;
        put_enq(0, 5'd1); tick();
        put_adr(5'd30, 32'h100); tick();
        exp_none("R2");
        put_adr(5'd1, 32'h100); tick();
        exp_ld("R7", 5'd1, 0, 0);
        tick(); exp_none("R5");
    endtask

    // R3 load behind a waiting store, R4 data-only store, R8 forwarding
    task automatic t_forward();
        put_enq(1, 5'd2); tick();
        put_enq(0, 5'd3); put_dat(5'd2); tick();
        exp_none("R4");
        put_adr(5'd3, 32'h200); tick();
        exp_none("R3");
        put_adr(5'd2, 32'h200); tick();
        exp_st("R4", 5'd2);
        tick(); exp_ld("R8", 5'd3, 1, 5'd2);
        tick(); exp_none("R8");
        put_cm(5'd2); tick();
    endtask

    // R4 store held by an older address-less load, then bypass counted (R9)
    task automatic t_bypass_single();
        cache_rdy = 0;
        put_enq(0, 5'd4); tick();
        put_enq(1, 5'd5); tick();
        put_adr(5'd5, 32'h300); put_dat(5'd5); tick();
        exp_none("R4");
        put_adr(5'd4, 32'h300); tick();
        exp_st("R4", 5'd5);
        tick(); exp_none("R3");
        cache_rdy = 1; exp_ld("R9", 5'd4, 0, 0);
        tick(); cache_rdy = 0;
        put_cm(5'd5); tick();
    endtask

    // R9 count back past one matching younger store, R6 foreign commit ignored
    task automatic t_count_back();
        cache_rdy = 0;
        put_enq(1, 5'd6); tick();
        put_adr(5'd6, 32'h400); put_dat(5'd6); put_enq(0, 5'd7); tick();
        exp_st("R4", 5'd6);
        put_enq(1, 5'd8); put_adr(5'd7, 32'h400); tick();
        put_enq(1, 5'd9); put_adr(5'd8, 32'h400); put_dat(5'd8); tick();
        exp_st("R9", 5'd8);
        put_adr(5'd9, 32'h500); put_dat(5'd9); tick();
        exp_st("R5", 5'd9);
        tick();
        put_cm(5'd20); tick();
        exp_none("R6");
        cache_rdy = 1; exp_ld("R9", 5'd7, 1, 5'd6);
        tick(); cache_rdy = 0;
        put_cm(5'd6); tick();
        put_cm(5'd8); tick();
        put_cm(5'd9); tick();
    endtask

    // R1 full queue drops an enqueue, R5 oldest-first order
    task automatic t_full_order();
        cache_rdy = 0;
        for (int k = 10; k < 18; k++) begin put_enq(0, 5'(k)); tick(); end
        #1 chk("R1", "q_full at 8", {31'd0, q_full}, 32'd1);
        put_enq(0, 5'd18); tick();
        for (int k = 17; k >= 10; k--) begin put_adr(5'(k), 32'h1000 + k); tick(); end
        exp_none("R3");
        cache_rdy = 1;
        for (int k = 10; k < 18; k++) begin
            exp_ld("R5", 5'(k), 0, 0);
            tick();
        end
        exp_none("R1");
        #1 chk("R1", "q_full drained", {31'd0, q_full}, 32'd0);
        cache_rdy = 0;
    endtask

    // R6 commit and store push in one cycle
    task automatic t_commit_push();
        cache_rdy = 0;
        put_enq(1, 5'd21); tick();
        put_adr(5'd21, 32'h600); put_dat(5'd21); put_enq(1, 5'd23); tick();
        exp_st("R4", 5'd21);
        put_adr(5'd23, 32'h700); put_dat(5'd23); tick();
        exp_st("R4", 5'd23);
        put_cm(5'd21); tick();
        put_enq(0, 5'd24); tick();
        put_enq(0, 5'd25); put_adr(5'd24, 32'h600); tick();
        put_adr(5'd25, 32'h700); tick();
        cache_rdy = 1; exp_ld("R6", 5'd24, 0, 0);
        tick(); exp_ld("R8", 5'd25, 1, 5'd23);
        tick(); cache_rdy = 0;
        put_cm(5'd23); tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_cache_read();
        t_forward();
        t_bypass_single();
        t_count_back();
        t_full_order();
        t_commit_push();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule